// File: doc/BRIEF.md
# Cycle-Steal Word Transfer Controller

This controller stores one word into a host processor's memory each time a local controller asks for it. It uses the processor's cycle-steal port to do so. The local controller raises a start level and presents an address and a data word. The block latches both, then requests a stolen memory cycle on priority level 0 and waits for the processor's grant. While the granted cycle runs, it drives the latched address and data toward the processor.

A stolen cycle lasts eight X-clock steps. The first four read the core location and the last four write it back. The instruction clock is frozen for the whole steal. Once step X6 is seen during the write half, the word has already been latched and stored, so the block stops driving. It then waits for the grant to fall and reports completion. It goes back to idle only after the local controller withdraws its start level, which gives a full four-phase handshake per word.

All processor-side inputs are resynchronised through a chain of flip-flops. The request, grant and X6 signals are active low. The request is withdrawn as soon as the grant is seen, so that only one cycle is stolen per word. An optional timeout abandons a request whose grant never arrives and raises an error flag. The timeout is disabled when `TMO_CYC` is 0.

States:
- `CS_IDLE`: waiting for a start.
- `CS_REQ`: request asserted, waiting for the grant.
- `CS_XFER`: bus driven, waiting for X6 in the write half.
- `CS_HOLD`: bus released, waiting for the grant to fall.
- `CS_DONE`: completion shown, waiting for start to drop.
- `CS_ERR`: timeout shown, waiting for start to drop.

Transitions:
- `CS_IDLE` to `CS_REQ` on start.
- `CS_REQ` to `CS_XFER` on the synchronised grant.
- `CS_REQ` to `CS_ERR` on timeout, when no grant is present in the same cycle.
- `CS_XFER` to `CS_HOLD` on synchronised X6 with the write cycle high.
- `CS_HOLD` to `CS_DONE` on the synchronised grant going high.
- `CS_DONE` to `CS_IDLE` on start low.
- `CS_ERR` to `CS_IDLE` on start low.

Top module: `cs_dma_ctrl`

## Requirements
- R1: After reset, `cs_req_n`=1, `bus_oe`=0, `host_done`=0, `host_err`=0, and `bus_addr` and `bus_data` are 0.
- R2: A high `host_start` in idle drives `cs_req_n` low after the next clock edge. The same edge latches `host_addr` and `host_data`.
- R3: After `cs_grant_n` goes low, `bus_oe` rises and `cs_req_n` returns high on the third clock edge. This latency comes from two synchroniser stages plus the state register. While `bus_oe`=1, the bus carries the latched address and data, and later changes on `host_addr` and `host_data` have no effect.
- R4: The drive is released on the third edge after `x6_n` falls while `stg_wr`=1, so `bus_oe` goes to 0. An X6 pulse while `stg_wr`=0 is ignored, and `bus_oe` stays 1.
- R5: After the drive is released, a rise of `cs_grant_n` sets `host_done`=1 on the third clock edge.
- R6: `host_done` stays 1 while `host_start` stays high. One edge after `host_start` falls, the block is idle again, and it accepts the next start at once.
- R7: If no synchronised grant is seen, `host_err` rises on edge `TMO_CYC`+1 counted from the start edge, and `cs_req_n` returns high. `host_err` stays 1 while `host_start` is high and clears one edge after `host_start` falls.
- R8: A grant that first appears at the synchroniser output in the last cycle of the timeout window wins over the timeout: the block drives the bus and `host_err` stays 0. A grant that arrives one cycle later loses, and the block enters the error state.
- R9: When `bus_oe`=0, `bus_addr` and `bus_data` are both 0.
- R10: A low `cs_grant_n` while the block is idle is ignored: `cs_req_n` stays 1 and `bus_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_start | input | 1 | Start level from the local controller |
| host_addr | input | AW | Target storage address |
| host_data | input | DW | Word to store |
| host_done | output | 1 | Word stored; waiting for start to drop |
| host_err | output | 1 | Grant timeout; waiting for start to drop |
| cs_req_n | output | 1 | Level-0 cycle-steal request, active low |
| cs_grant_n | input | 1 | Level-0 cycle-steal grant, active low |
| x6_n | input | 1 | X-clock step 6, active low |
| stg_wr | input | 1 | Storage write half in progress, active high |
| bus_oe | output | 1 | Drive enable for address and data |
| bus_addr | output | AW | Address driven to the processor, 0 when not driving |
| bus_data | output | DW | Data driven to the processor, 0 when not driving |

## Verification
The timeout expiry and the arrival of the synchronised grant can fall in the same cycle. The bench provokes this by lowering the grant just early enough that its second synchroniser stage turns low on the edge where the timeout counter reaches its final value. It then checks that the bus is driven on the expected edge and that no error is raised. A second run lowers the grant one cycle later and expects the error state with the request withdrawn. Random transfers with varying grant, X6 and release delays, plus ignored X6 pulses outside the write half, exercise the rest of the handshake.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [2:0] {
        CS_IDLE = 3'd0,
        CS_REQ  = 3'd1,
        CS_XFER = 3'd2,
        CS_HOLD = 3'd3,
        CS_DONE = 3'd4,
        CS_ERR  = 3'd5
    } cs_state_e;

endpackage

// File: rtl/cs_dma_sync.sv
module cs_dma_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) chain[i] <= RST;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < NS; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[NS-1];
endmodule

// File: rtl/cs_dma_tmo.sv
module cs_dma_tmo #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    generate
        if (TMO_CYC == 0) begin : g_off
            logic never_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) never_q <= 1'b0;
                else        never_q <= en & 1'b0;
            end
            assign hit = never_q;
        end else begin : g_on
            localparam int CW = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
            localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           cnt <= '0;
                else if (!en)         cnt <= '0;
                else if (cnt != LAST) cnt <= cnt + 1'b1;
            end
            assign hit = en && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/cs_dma_fsm.sv
module cs_dma_fsm
    import cs_dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      grant_n_s,
    input  logic      x6_n_s,
    input  logic      wr_s,
    input  logic      tmo_hit,
    output cs_state_e state,
    output logic      load,
    output logic      req_n,
    output logic      drive,
    output logic      done,
    output logic      err,
    output logic      tmo_en
);
    cs_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE: if (start)             nxt = CS_REQ;
            CS_REQ: begin
                if (!grant_n_s)             nxt = CS_XFER;
                else if (tmo_hit)           nxt = CS_ERR;
            end
            CS_XFER: if (!x6_n_s && wr_s)   nxt = CS_HOLD;
            CS_HOLD: if (grant_n_s)         nxt = CS_DONE;
            CS_DONE: if (!start)            nxt = CS_IDLE;
            CS_ERR:  if (!start)            nxt = CS_IDLE;
            default:                        nxt = CS_IDLE;
        endcase
    end

    always_comb begin
        load   = 1'b0;
        req_n  = 1'b1;
        drive  = 1'b0;
        done   = 1'b0;
        err    = 1'b0;
        tmo_en = 1'b0;
        unique case (state)
            CS_IDLE: load = start;
            CS_REQ: begin
                req_n  = 1'b0;
                tmo_en = 1'b1;
            end
            CS_XFER: drive = 1'b1;
            CS_HOLD: ;
            CS_DONE: done = 1'b1;
            CS_ERR:  err  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
    import cs_dma_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int TMO_CYC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_start,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    output logic          host_done,
    output logic          host_err,
    output logic          cs_req_n,
    input  logic          cs_grant_n,
    input  logic          x6_n,
    input  logic          stg_wr,
    output logic          bus_oe,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data
);
    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b011;

    logic [NSYNC-1:0] proc_raw, proc_s;
    logic             grant_n_s, x6_n_s, wr_s;
    logic             tmo_en, tmo_hit, load, drive;
    cs_state_e        state;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;

    assign proc_raw  = {stg_wr, x6_n, cs_grant_n};
    assign grant_n_s = proc_s[0];
    assign x6_n_s    = proc_s[1];
    assign wr_s      = proc_s[2];

    cs_dma_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (proc_raw),
        .q     (proc_s)
    );

    cs_dma_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmo_en),
        .hit   (tmo_hit)
    );

    cs_dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (host_start),
        .grant_n_s (grant_n_s),
        .x6_n_s    (x6_n_s),
        .wr_s      (wr_s),
        .tmo_hit   (tmo_hit),
        .state     (state),
        .load      (load),
        .req_n     (cs_req_n),
        .drive     (drive),
        .done      (host_done),
        .err       (host_err),
        .tmo_en    (tmo_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= host_addr;
            data_q <= host_data;
        end
    end

    assign bus_oe   = drive;
    assign bus_addr = drive ? addr_q : '0;
    assign bus_data = drive ? data_q : '0;
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_start,
    input logic          host_done,
    input logic          host_err,
    input logic          cs_req_n,
    input logic          bus_oe,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_data
);
    AST_REQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_req_n) |-> $past(host_start)); // R2

    AST_NO_REQ_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> cs_req_n); // R3

    AST_DRIVE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(!cs_req_n)); // R3

    AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> ($stable(bus_addr) && $stable(bus_data))); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (!host_err && !bus_oe && cs_req_n)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done && host_start) |=> host_done); // R6

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err && host_start) |=> (host_err && cs_req_n)); // R7

    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_addr == '0 && bus_data == '0)); // R9
endmodule

bind cs_dma_ctrl cs_dma_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_start (host_start),
    .host_done  (host_done),
    .host_err   (host_err),
    .cs_req_n   (cs_req_n),
    .bus_oe     (bus_oe),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data)
);

// File: tb/test_cs_dma_ctrl.sv
`timescale 1ns/1ps
module test_cs_dma_ctrl;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_start = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic          host_done, host_err, cs_req_n, bus_oe;
    logic          cs_grant_n = 1'b1;
    logic          x6_n = 1'b1;
    logic          stg_wr = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cs_dma_ctrl #(.AW(AW), .DW(DW), .TMO_CYC(TMO), .SYNC_STAGES(2)) i_cs_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_addr(host_addr),
        .host_data(host_data), .host_done(host_done), .host_err(host_err),
        .cs_req_n(cs_req_n), .cs_grant_n(cs_grant_n), .x6_n(x6_n), .stg_wr(stg_wr),
        .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_data(bus_data)
    );

    function automatic int exp_sync_lat();
        return 3;
    endfunction

    function automatic int exp_tmo_edges();
        return TMO + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sel 0: bus_oe high, 1: bus_oe low, 2: host_done high, 3: bus_oe or host_err high
    task automatic count_until(input int sel, output int n);
        bit hit;
        n = 0;
        hit = 1'b0;
        while (!hit && n < 40) begin
            @(posedge clk); #1;
            n++;
            case (sel)
                0: hit = bus_oe;
                1: hit = !bus_oe;
                2: hit = host_done;
                default: hit = bus_oe || host_err;
            endcase
        end
    endtask

    task automatic finish_xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input int xdly, input int rdly, input bit pulse);
        int n;
        if (pulse) begin
            @(negedge clk); x6_n = 1'b0; stg_wr = 1'b0;
            repeat (2) @(negedge clk);
            x6_n = 1'b1;
            repeat (4) @(posedge clk);
            #1;
            chk(bus_oe == 1'b1, "R4 x6 outside write half ignored", bus_oe, 1);
            chk(bus_addr == a, "R3 address held", bus_addr, a);
        end
        @(negedge clk);
        repeat (xdly) @(negedge clk);
        stg_wr = 1'b1; x6_n = 1'b0;
        count_until(1, n);
        chk(n == exp_sync_lat(), "R4 release latency", n, exp_sync_lat());
        chk(bus_addr == '0 && bus_data == '0, "R9 bus zero after release", {bus_addr, bus_data}, 0);
        @(negedge clk); x6_n = 1'b1; stg_wr = 1'b0;
        repeat (rdly) @(negedge clk);
        cs_grant_n = 1'b1;
        count_until(2, n);
        chk(n == exp_sync_lat(), "R5 done latency", n, exp_sync_lat());
        repeat (3) @(posedge clk);
        #1;
        chk(host_done == 1'b1, "R6 done held while start high", host_done, 1);
        @(negedge clk); host_start = 1'b0;
        @(posedge clk); #1;
        chk(!host_done && cs_req_n && !bus_oe, "R6 idle after start drop",
            {host_done, cs_req_n, bus_oe}, 3'b010);
        if (d == 0) chk(1'b1, "R6", 0, 0);
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int gdly, input int xdly, input int rdly, input bit pulse);
        int n;
        @(negedge clk);
        host_start = 1'b1; host_addr = a; host_data = d;
        @(posedge clk); #1;
        chk(cs_req_n == 1'b0, "R2 request after start", cs_req_n, 0);
        chk(bus_oe == 1'b0, "R9 no drive while requesting", bus_oe, 0);
        @(negedge clk);
        host_addr = ~a; host_data = ~d;
        repeat (gdly) @(negedge clk);
        cs_grant_n = 1'b0;
        count_until(0, n);
        chk(n == exp_sync_lat(), "R3 drive latency", n, exp_sync_lat());
        chk(cs_req_n == 1'b1, "R3 request withdrawn at grant", cs_req_n, 1);
        chk(bus_addr == a, "R3 latched address", bus_addr, a);
        chk(bus_data == d, "R3 latched data", bus_data, d);
        finish_xfer(a, d, xdly, rdly, pulse);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        #1;
        chk(cs_req_n && !bus_oe && !host_done && !host_err && bus_addr == 0 && bus_data == 0,
            "R1 reset outputs", {cs_req_n, bus_oe, host_done, host_err}, 4'b1000);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cs_req_n && !bus_oe && !host_done && !host_err, "R1 after reset release",
            {cs_req_n, bus_oe, host_done, host_err}, 4'b1000);

        // R10: grant while idle is ignored
        @(negedge clk); cs_grant_n = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        chk(cs_req_n == 1'b1 && bus_oe == 1'b0, "R10 idle grant ignored", {cs_req_n, bus_oe}, 2'b10);
        @(negedge clk); cs_grant_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed patterns, then random ones
        xfer(16'h0100, 16'h0000, 0, 0, 0, 1'b0);
        xfer(16'h0101, 16'hFFFF, 6, 5, 5, 1'b1);
        for (int i = 0; i < 8; i++) begin
            xfer(AW'($urandom), DW'($urandom), $urandom_range(0, 6),
                 $urandom_range(0, 5), $urandom_range(0, 5), 1'($urandom));
        end

        // R7: grant never arrives
        @(negedge clk); host_start = 1'b1; host_addr = 16'h1234; host_data = 16'h5678;
        count_until(3, n);
        chk(n == exp_tmo_edges(), "R7 timeout edge", n, exp_tmo_edges());
        chk(host_err && cs_req_n && !bus_oe, "R7 error state outputs",
            {host_err, cs_req_n, bus_oe}, 3'b110);
        repeat (3) @(posedge clk);
        #1;
        chk(host_err == 1'b1, "R7 error held", host_err, 1);
        @(negedge clk); host_start = 1'b0;
        @(posedge clk); #1;
        chk(host_err == 1'b0 && cs_req_n == 1'b1, "R7 error cleared", host_err, 0);

        // R8: grant reaches the FSM on the final timeout cycle and wins
        @(negedge clk); host_start = 1'b1; host_addr = 16'h00FF; host_data = 16'hA5A5;
        repeat (TMO - 2) @(posedge clk);
        @(negedge clk); cs_grant_n = 1'b0;
        count_until(3, n);
        chk(n == exp_sync_lat() && bus_oe && !host_err, "R8 grant wins tie",
            {n[7:0], bus_oe, host_err}, {8'(exp_sync_lat()), 2'b10});
        chk(bus_data == 16'hA5A5, "R8 data driven after tie", bus_data, 16'hA5A5);
        finish_xfer(16'h00FF, 16'hA5A5, 1, 1, 1'b0);

        // R8: grant one cycle later loses
        @(negedge clk); host_start = 1'b1; host_addr = 16'h1013; host_data = 16'h5A5A;
        repeat (TMO - 1) @(posedge clk);
        @(negedge clk); cs_grant_n = 1'b0;
        count_until(3, n);
        chk(n == 2 && host_err && !bus_oe, "R8 late grant loses",
            {n[7:0], host_err, bus_oe}, {8'd2, 2'b10});
        @(negedge clk); cs_grant_n = 1'b1; host_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!host_err && cs_req_n && !bus_oe, "R8 idle after late grant",
            {host_err, cs_req_n, bus_oe}, 3'b010);

        xfer(16'h0102, 16'h5A5A, 2, 2, 2, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule